// File: doc/BRIEF.md
# Dual-Channel Interrupt Arming Gate

This block sits between the request lines of a two-channel disk interface card and the host's single interrupt input. Each channel owns two byte-wide register addresses: an arm/disarm address and a status address. Any write to the arm/disarm address, whatever the data, arms that channel. A read of the same address disarms it. No mask register holds data bits, so software arms a channel with a dummy write and silences it with a dummy read.

The status address always returns the channel's synchronized request level in bit 0, whether or not the channel is armed. The host interrupt line is asserted when any armed channel has an active request. A separate pending output shows whether any request is active at all. Software can leave an unpopulated channel permanently disarmed, so its floating request line never reaches the host. A parameter reduces the block to a single channel; the second channel's addresses then decode as unmapped.

Top module: `dual_irq_gate`

## Requirements
- R1: After reset both channel arm flags are clear, `irq_o` and `rd_valid_o` are low, and `pending_o` is low while no request is active.
- R2: A write strobe of any data value to a channel's arm address (channel 0 at 0x040, channel 1 at 0x050 by default) arms that channel from the next clock edge.
- R3: A read strobe to a channel's arm address disarms that channel from the next clock edge, and the read returns 0x00.
- R4: `irq_o` is the OR over channels of each synchronized request ANDed with that channel's arm flag, so an active request on a disarmed channel raises no interrupt.
- R5: `pending_o` is the OR of the synchronized requests of all channels, independent of the arm flags.
- R6: A read of a channel's status address (channel 0 at 0x048, channel 1 at 0x058 by default) returns the synchronized request level in bit 0 and zero in bits 7 to 1, and changes no arm flag.
- R7: Read data appears on `rd_data_o` with `rd_valid_o` high for exactly one cycle, one clock edge after the read strobe.
- R8: Reads and writes to any other address change no arm flag, and such reads return 0x00.
- R9: When a read and a write strobe hit the same arm address in one cycle, the channel ends disarmed.
- R10: Each request input passes through `SYNC_STAGES` flip-flops (default 2) before it affects `irq_o`, `pending_o` or status reads.
- R11: With `NUM_CH` set to 1, only channel 0's addresses are decoded; a write to channel 1's arm address arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data (ignored by the gate) |
| req_in | input | NUM_CH | Raw request line per channel |
| irq_o | output | 1 | Combined interrupt to the host |
| pending_o | output | 1 | Any synchronized request active |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle |

## Verification
The assertions check on every cycle that a write hit arms and a read hit disarms the addressed flag. They check that a flag is stable when its channel is not addressed, that decoded hits are mutually exclusive, and that the interrupt is never raised without a pending request. They also check the one-cycle read latency and that the upper status bits read as zero. Only the bench scenarios can show the end-to-end behaviour: that any data value arms a channel, that a status read leaves an armed channel armed, the synchronizer delay on the requests, the disarm-wins collision, and the reduced single-channel decode.

// File: rtl/dual_irq_gate_pkg.sv
package dual_irq_gate_pkg;

  // Address of channel k's arm/disarm register.
  function automatic int unsigned arm_addr(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned k);
    return base + k * stride;
  endfunction

  // Address of channel k's status register.
  function automatic int unsigned stat_addr(input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned k);
    return base + k * stride;
  endfunction

  // Status bit for one read: request level of the channel whose status
  // address was hit, zero when no status address was hit.
  function automatic logic stat_bit(input logic [7:0] hits,
                                    input logic [7:0] levels);
    return |(hits & levels);
  endfunction

endpackage

// File: rtl/dig_decode.sv
module dig_decode
  import dual_irq_gate_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int ADDR_W    = 12,
  parameter int ARM_BASE  = 'h040,
  parameter int STAT_BASE = 'h048,
  parameter int CH_STRIDE = 'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NUM_CH-1:0] arm_hit,
  output logic [NUM_CH-1:0] disarm_hit,
  output logic [NUM_CH-1:0] stat_hit
);

  logic [NUM_CH-1:0] arm_match;
  logic [NUM_CH-1:0] stat_match;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] ARM_A =
      ADDR_W'(arm_addr(ARM_BASE, CH_STRIDE, k));
    localparam logic [ADDR_W-1:0] STAT_A =
      ADDR_W'(stat_addr(STAT_BASE, CH_STRIDE, k));
    assign arm_match[k]  = (addr == ARM_A);
    assign stat_match[k] = (addr == STAT_A);
    assign arm_hit[k]    = wr & arm_match[k];
    assign disarm_hit[k] = rd & arm_match[k];
    assign stat_hit[k]   = rd & stat_match[k];
  end

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_match, stat_match})) else $error("decode overlap"); // R8

endmodule

// File: rtl/dig_chan.sv
module dig_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_raw,
  input  logic arm,
  input  logic disarm,
  output logic req_sync,
  output logic armed,
  output logic irq_term
);

  if (SYNC_STAGES == 0) begin : g_nosync
    assign req_sync = req_raw;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[SYNC_STAGES-2+1-1:0], req_raw};
    end
    assign req_sync = stage_q[SYNC_STAGES-1];
  end

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (disarm) armed_q <= 1'b0;
    else if (arm)    armed_q <= 1'b1;
  end

  assign armed    = armed_q;
  assign irq_term = req_sync & armed_q;

  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !disarm) |=> armed) else $error("arm lost"); // R2
  AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !armed) else $error("disarm lost"); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !disarm) |=> $stable(armed)) else $error("flag moved"); // R8

endmodule

// File: rtl/dig_rdmux.sv
module dig_rdmux
  import dual_irq_gate_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [NUM_CH-1:0] stat_hit,
  input  logic [NUM_CH-1:0] req_sync,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              status_level;

  assign status_level = stat_bit(8'(stat_hit), 8'(req_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd;
      data_q  <= rd ? DATA_W'(status_level) : '0;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid) else $error("late read"); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:1] == '0)) else $error("upper bits"); // R6

endmodule

// File: rtl/dual_irq_gate.sv
module dual_irq_gate #(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ARM_BASE    = 'h040,
  parameter int STAT_BASE   = 'h048,
  parameter int CH_STRIDE   = 'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_CH-1:0] req_in,
  output logic              irq_o,
  output logic              pending_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  logic [NUM_CH-1:0] arm_hit;
  logic [NUM_CH-1:0] disarm_hit;
  logic [NUM_CH-1:0] stat_hit;
  logic [NUM_CH-1:0] req_sync;
  logic [NUM_CH-1:0] armed;
  logic [NUM_CH-1:0] irq_term;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata;

  dig_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .ARM_BASE(ARM_BASE),
    .STAT_BASE(STAT_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .arm_hit(arm_hit), .disarm_hit(disarm_hit), .stat_hit(stat_hit)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    dig_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk(clk), .rst_n(rst_n), .req_raw(req_in[k]),
      .arm(arm_hit[k]), .disarm(disarm_hit[k]),
      .req_sync(req_sync[k]), .armed(armed[k]), .irq_term(irq_term[k])
    );
  end

  dig_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .stat_hit(stat_hit),
    .req_sync(req_sync), .rd_data(rd_data_o), .rd_valid(rd_valid_o)
  );

  assign irq_o     = |irq_term;
  assign pending_o = |req_sync;

  AST_IRQ_IMPLIES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pending_o) else $error("irq without pending"); // R5
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (armed != '0)) else $error("irq while disarmed"); // R4

endmodule

// File: tb/dual_irq_gate_bench.sv
module dual_irq_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ARM0  = 12'h040;
  localparam logic [11:0] A_STAT0 = 12'h048;
  localparam logic [11:0] A_ARM1  = 12'h050;
  localparam logic [11:0] A_STAT1 = 12'h058;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  req_in = '0;
  logic        irq_o, pending_o, rd_valid_o;
  logic [7:0]  rd_data_o;
  logic        s_irq, s_pend, s_rvalid;
  logic [7:0]  s_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_gate u_dual_irq_gate (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .req_in(req_in),
    .irq_o(irq_o), .pending_o(pending_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  dual_irq_gate #(.NUM_CH(1)) u_dual_irq_gate_single (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .req_in(req_in[0]),
    .irq_o(s_irq), .pending_o(s_pend), .rd_data_o(s_rdata),
    .rd_valid_o(s_rvalid)
  );

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: one bus access; a read pushes its expected data to the scoreboard.
  task automatic access(input logic [11:0] a, input logic w, input logic r,
                        input logic [7:0] d, input logic [7:0] exp,
                        input string req);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    if (r) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare each read result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual unexpected read data %0h expected none", rd_data_o);
      end else begin
        check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    check("R1 pending", {7'd0, pending_o}, 8'd0);
    check("R1 rd_valid", {7'd0, rd_valid_o}, 8'd0);

    // Request on channel 0 while disarmed; synchronizer delay.
    req_in = 2'b01;
    @(negedge clk);
    check("R10 after one edge", {7'd0, pending_o}, 8'd0);
    @(negedge clk);
    check("R10 R5 after two edges", {7'd0, pending_o}, 8'd1);
    check("R1 R4 disarmed after reset", {7'd0, irq_o}, 8'd0);

    access(A_ARM0, 1'b1, 1'b0, 8'hA5, 8'h00, "");
    check("R2 arm ch0", {7'd0, irq_o}, 8'd1);
    check("R11 single arms ch0", {7'd0, s_irq}, 8'd1);

    req_in = 2'b10;
    wait_cycles(2);
    check("R4 ch1 disarmed", {7'd0, irq_o}, 8'd0);
    check("R5 pending ch1", {7'd0, pending_o}, 8'd1);

    access(A_STAT1, 1'b0, 1'b1, 8'h00, 8'h01, "R6 status ch1");
    check("R7 valid one cycle", {7'd0, rd_valid_o}, 8'd1);
    @(negedge clk);
    check("R7 valid drops", {7'd0, rd_valid_o}, 8'd0);
    access(A_STAT0, 1'b0, 1'b1, 8'h00, 8'h00, "R6 status ch0");

    req_in = 2'b11;
    wait_cycles(2);
    check("R6 status read kept ch0 armed", {7'd0, irq_o}, 8'd1);

    access(A_ARM0, 1'b0, 1'b1, 8'h00, 8'h00, "R3 arm read data");
    check("R3 disarm ch0", {7'd0, irq_o}, 8'd0);

    access(12'h044, 1'b1, 1'b0, 8'hFF, 8'h00, "");
    access(12'h060, 1'b1, 1'b0, 8'hFF, 8'h00, "");
    access(12'h04C, 1'b0, 1'b1, 8'h00, 8'h00, "R8 unmapped read");
    check("R8 unmapped writes arm nothing", {7'd0, irq_o}, 8'd0);

    access(A_ARM1, 1'b1, 1'b0, 8'h00, 8'h00, "");
    check("R2 arm ch1 with zero data", {7'd0, irq_o}, 8'd1);
    check("R11 single ignores ch1 address", {7'd0, s_irq}, 8'd0);

    access(A_ARM1, 1'b1, 1'b1, 8'h5A, 8'h00, "R9 collision read data");
    check("R9 disarm wins", {7'd0, irq_o}, 8'd0);

    access(A_ARM0, 1'b1, 1'b0, 8'h01, 8'h00, "");
    check("R2 rearm ch0", {7'd0, irq_o}, 8'd1);
    req_in = 2'b00;
    wait_cycles(2);
    check("R4 request gone", {7'd0, irq_o}, 8'd0);
    check("R5 pending gone", {7'd0, pending_o}, 8'd0);

    wait_cycles(2);
    check("R7 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule